// File: doc/BRIEF.md
# DMA Request and Completion Status for a Serial Port FIFO Pair

This block sits beside the receive and transmit FIFOs of a synchronous serial port. It watches how many entries the receive FIFO holds and how many entries the transmit FIFO holds. From these counts it raises DMA request lines for each direction. There are two lines per direction. The single request asks the DMA controller to move one item. The burst request tells the controller that at least four items can be moved. The burst threshold is the parameter `BURST_TH`, with a default of 4. Each direction's DMA enable input gates both of that direction's request lines.

The block also holds three raw status flags:
- a receive-done flag, set by a completion strobe from the DMA controller for the receive channel;
- a transmit-done flag, set by a completion strobe from the DMA controller for the transmit channel;
- an end-of-transmission flag, high when the transmit FIFO is empty and the serializer reports that it is idle.

Software clears a done flag by writing one to its clear strobe. A clear of the transmit-done flag only takes effect once transmit DMA has been disabled. The service routine therefore turns off the transmit enable first, then clears the flag, and enables transmit DMA again when more data is ready.

Top module: `fifo_dma_req`

## Requirements
- R1: `rx_single_req` is high in the same cycle whenever `rx_dma_en` is 1 and `rx_level` is at least 1.
- R2: `rx_burst_req` is high in the same cycle whenever `rx_dma_en` is 1 and `rx_level` is at least `BURST_TH` (default 4).
- R3: `tx_single_req` is high in the same cycle whenever `tx_dma_en` is 1 and the free slots `DEPTH - tx_level` number at least 1.
- R4: `tx_burst_req` is high in the same cycle whenever `tx_dma_en` is 1 and the free slots `DEPTH - tx_level` number at least `BURST_TH`.
- R5: While a direction's enable is 0, both of that direction's request lines are 0, whatever the FIFO count is.
- R6: A one-cycle pulse on `tx_xfer_done` sets `tx_done_raw` at the next clock edge. A `clr_tx_done` pulse while `tx_dma_en` is 1 leaves the flag set.
- R7: A `clr_tx_done` pulse while `tx_dma_en` is 0 clears `tx_done_raw` at the next clock edge.
- R8: A pulse on `rx_xfer_done` sets `rx_done_raw` at the next edge. A `clr_rx_done` pulse clears it at the next edge, whatever the value of `rx_dma_en`.
- R9: When a done strobe and its clear strobe arrive in the same cycle, the flag is set after the edge.
- R10: `eot_raw` is 1 one cycle after a cycle in which `tx_level` is 0 and `ser_idle` is 1. Otherwise it is 0 one cycle later.
- R11: While `rst_n` is low, all three status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level | input | LVL_W | Entries held in the receive FIFO |
| tx_level | input | LVL_W | Entries held in the transmit FIFO |
| rx_dma_en | input | 1 | Enables receive DMA requests |
| tx_dma_en | input | 1 | Enables transmit DMA requests |
| rx_xfer_done | input | 1 | Strobe: DMA finished a receive transfer |
| tx_xfer_done | input | 1 | Strobe: DMA finished a transmit transfer |
| ser_idle | input | 1 | Serializer has shifted out its last bit |
| clr_rx_done | input | 1 | Write-one-to-clear strobe for the receive-done flag |
| clr_tx_done | input | 1 | Write-one-to-clear strobe for the transmit-done flag |
| rx_single_req | output | 1 | Receive single request |
| rx_burst_req | output | 1 | Receive burst request |
| tx_single_req | output | 1 | Transmit single request |
| tx_burst_req | output | 1 | Transmit burst request |
| rx_done_raw | output | 1 | Raw receive-done status |
| tx_done_raw | output | 1 | Raw transmit-done status |
| eot_raw | output | 1 | Raw end-of-transmission status |

## Verification
The four request lines are combinational, so they are due in the same cycle as the counts and enables that produce them. The three status flags are registered, so they respond one clock edge after the strobe, clear or level condition that drives them. The bench drives each new input set on the falling clock edge. On the next falling edge it first advances its reference model by the one rising edge that has passed. It then compares the requests against the inputs still being held and the flags against the model's updated state. Every latency is therefore checked in exactly the cycle it is due.

// File: rtl/fifo_dma_req.sv
module fifo_dma_req #(
  parameter int DEPTH    = 8,
  parameter int BURST_TH = 4,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             rx_dma_en,
  input  logic             tx_dma_en,
  input  logic             rx_xfer_done,
  input  logic             tx_xfer_done,
  input  logic             ser_idle,
  input  logic             clr_rx_done,
  input  logic             clr_tx_done,
  output logic             rx_single_req,
  output logic             rx_burst_req,
  output logic             tx_single_req,
  output logic             tx_burst_req,
  output logic             rx_done_raw,
  output logic             tx_done_raw,
  output logic             eot_raw
);

  localparam logic [LVL_W-1:0] DEPTH_V = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] BURST_V = LVL_W'(BURST_TH);

  logic [LVL_W-1:0] tx_free;
  assign tx_free = DEPTH_V - tx_level;

  assign rx_single_req = rx_dma_en && (rx_level != '0);
  assign rx_burst_req  = rx_dma_en && (rx_level >= BURST_V);
  assign tx_single_req = tx_dma_en && (tx_free != '0);
  assign tx_burst_req  = tx_dma_en && (tx_free >= BURST_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_done_raw <= 1'b0;
      tx_done_raw <= 1'b0;
      eot_raw     <= 1'b0;
    end else begin
      if (rx_xfer_done)                   rx_done_raw <= 1'b1;
      else if (clr_rx_done)               rx_done_raw <= 1'b0;
      if (tx_xfer_done)                   tx_done_raw <= 1'b1;
      else if (clr_tx_done && !tx_dma_en) tx_done_raw <= 1'b0;
      eot_raw <= (tx_level == '0) && ser_idle;
    end
  end

endmodule

module fifo_dma_req_chk #(
  parameter int DEPTH    = 8,
  parameter int BURST_TH = 4,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_level,
  input logic             rx_dma_en,
  input logic             tx_dma_en,
  input logic             rx_xfer_done,
  input logic             tx_xfer_done,
  input logic             ser_idle,
  input logic             clr_rx_done,
  input logic             clr_tx_done,
  input logic             rx_single_req,
  input logic             rx_burst_req,
  input logic             tx_single_req,
  input logic             tx_burst_req,
  input logic             rx_done_raw,
  input logic             tx_done_raw,
  input logic             eot_raw
);

  a_r2_rx_burst_implies_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_burst_req |-> rx_single_req);
  a_r4_tx_burst_implies_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_burst_req |-> tx_single_req);
  a_r5_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dma_en |-> !(rx_single_req || rx_burst_req));
  a_r5_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_dma_en |-> !(tx_single_req || tx_burst_req));
  a_r6_tx_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_xfer_done |=> tx_done_raw);
  a_r6_tx_done_sticky_while_en: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_raw && tx_dma_en) |=> tx_done_raw);
  a_r7_tx_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tx_done && !tx_dma_en && !tx_xfer_done) |=> !tx_done_raw);
  a_r8_rx_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_xfer_done |=> rx_done_raw);
  a_r8_rx_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rx_done && !rx_xfer_done) |=> !rx_done_raw);
  a_r10_eot_cause: assert property (@(posedge clk) disable iff (!rst_n)
    eot_raw |-> $past(ser_idle && (tx_level == '0)));

endmodule

bind fifo_dma_req fifo_dma_req_chk #(.DEPTH(DEPTH), .BURST_TH(BURST_TH)) u_chk (.*);

// File: tb/sim_fifo_dma_req.sv
module sim_fifo_dma_req;
  localparam int DEPTH = 8;
  localparam int BTH   = 4;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LW-1:0] rx_level = '0, tx_level = '0;
  logic rx_dma_en = 0, tx_dma_en = 0, rx_xfer_done = 0, tx_xfer_done = 0;
  logic ser_idle = 0, clr_rx_done = 0, clr_tx_done = 0;
  logic rx_single_req, rx_burst_req, tx_single_req, tx_burst_req;
  logic rx_done_raw, tx_done_raw, eot_raw;

  int checks = 0, errors = 0;
  bit m_rx = 0, m_tx = 0, m_eot = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fifo_dma_req #(.DEPTH(DEPTH), .BURST_TH(BTH)) u0 (.*);

  task automatic chk(string tag, string name, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic cyc();
    int free;
    @(negedge clk);
    if (!rst_n) begin
      m_rx = 0; m_tx = 0; m_eot = 0;
    end else begin
      if (rx_xfer_done) m_rx = 1; else if (clr_rx_done) m_rx = 0;
      if (tx_xfer_done) m_tx = 1; else if (clr_tx_done && !tx_dma_en) m_tx = 0;
      m_eot = (int'(tx_level) == 0) && ser_idle;
    end
    free = DEPTH - int'(tx_level);
    chk(rx_dma_en ? "R1" : "R5", "rx_single", rx_single_req, rx_dma_en && int'(rx_level) >= 1);
    chk(rx_dma_en ? "R2" : "R5", "rx_burst", rx_burst_req, rx_dma_en && int'(rx_level) >= BTH);
    chk(tx_dma_en ? "R3" : "R5", "tx_single", tx_single_req, tx_dma_en && free >= 1);
    chk(tx_dma_en ? "R4" : "R5", "tx_burst", tx_burst_req, tx_dma_en && free >= BTH);
    chk(!rst_n ? "R11" : "R8 R9", "rx_done", rx_done_raw, m_rx);
    chk(!rst_n ? "R11" : "R6 R7 R9", "tx_done", tx_done_raw, m_tx);
    chk(!rst_n ? "R11" : "R10", "eot", eot_raw, m_eot);
  endtask

  task automatic pulse_clear();
    rx_xfer_done = 0; tx_xfer_done = 0; clr_rx_done = 0; clr_tx_done = 0;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset state, with strobes active during reset
    rx_xfer_done = 1; tx_xfer_done = 1; ser_idle = 1;
    repeat (3) cyc();
    pulse_clear();
    rst_n = 1;
    cyc();
    // R1 R2 R3 R4 R5: sweep every count with each enable combination
    for (int e = 0; e < 4; e++) begin
      rx_dma_en = e[0]; tx_dma_en = e[1];
      for (int l = 0; l <= DEPTH; l++) begin
        rx_level = LW'(l); tx_level = LW'(DEPTH - l);
        cyc();
      end
    end
    // R6: set, then clear ignored while the transmit enable is high
    tx_dma_en = 1; tx_xfer_done = 1; cyc();
    pulse_clear(); clr_tx_done = 1; cyc();
    cyc();
    // R7: disable the enable, then clear
    pulse_clear(); tx_dma_en = 0; cyc();
    clr_tx_done = 1; cyc();
    pulse_clear(); cyc();
    // R9: set and clear in the same cycle
    tx_xfer_done = 1; clr_tx_done = 1; rx_xfer_done = 1; clr_rx_done = 1; cyc();
    pulse_clear(); cyc();
    // R8: receive clear works with the receive enable high
    rx_dma_en = 1; clr_rx_done = 1; cyc();
    pulse_clear(); cyc();
    // R10: end of transmission follows level and idle
    tx_level = '0; ser_idle = 0; cyc();
    ser_idle = 1; cyc();
    cyc();
    tx_level = LW'(1); cyc();
    cyc();
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      rx_level     = LW'($urandom_range(DEPTH, 0));
      tx_level     = LW'($urandom_range(DEPTH, 0));
      rx_dma_en    = $urandom_range(3, 0) != 0;
      tx_dma_en    = $urandom_range(1, 0) != 0;
      rx_xfer_done = $urandom_range(7, 0) == 0;
      tx_xfer_done = $urandom_range(7, 0) == 0;
      clr_rx_done  = $urandom_range(3, 0) == 0;
      clr_tx_done  = $urandom_range(3, 0) == 0;
      ser_idle     = $urandom_range(1, 0) != 0;
      if ($urandom_range(3, 0) == 0) tx_level = '0;
      cyc();
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule